// File: doc/BRIEF.md
# Host Reset Supervisor with Programmable Release Delay

This block generates the active-low reset line for a host processor from two groups of internal reset requests. Soft requests pull the line low but leave the device running with its supplies enabled. Hard requests pull the line low, stop the supplies and park the block in a fault state. A fault state is only left through an explicit recovery strobe.

Once no request is pending, the line stays low for a programmable number of delay ticks before it is released. One tick lasts 10 µs and comes from a prescaler on the system clock. Software sets the delay through a write port. Any value it writes is limited to the legal window of 20 to 2000 ticks, and the stored value is always visible on a read-back port.

The controller has four states. The 2-bit code on `state_o` is ACTIVE = 0, SOFT = 1, HOLD = 2 and FAULT = 3.

- **ACTIVE**: the host runs, the reset line is high and the supplies are on.
- **SOFT**: a soft request is pending. The line is low and the supplies stay on.
- **HOLD**: no request is pending and the release delay is being counted. The line is low and the supplies are on.
- **FAULT**: a hard request was seen. The line is low and the supplies are off.

The transitions are:

- **any → FAULT** on a hard request. This has the highest priority in every state.
- **ACTIVE → SOFT** and **HOLD → SOFT** on a soft request.
- **SOFT → HOLD** when every soft request has cleared.
- **HOLD → ACTIVE** when the delay counter expires.
- **FAULT → SOFT** or **FAULT → HOLD** on a recovery strobe with no hard request pending. The target is SOFT if a soft request is pending, and HOLD otherwise.
- **Reset** places the block in HOLD.

Top module: `rstsup_top`

## Requirements
- R1: When any soft or hard request is sampled high at a clock edge, `host_rst_n` is 0 in the cycle that follows that edge.
- R2: `host_rst_n` rises only after all requests are low and the block has then spent exactly DELAY × DIV consecutive cycles in HOLD (`state_o` = 2). DIV is the number of clocks per tick.
- R3: A delay tick occurs every DIV = CLK_HZ / 100000 clock cycles while HOLD is active, with the first tick DIV cycles after HOLD is entered.
- R4: A write on `cfg_we` stores `cfg_wdata` limited to the range 20 to 2000. `cfg_delay` shows the stored, limited value from the cycle after the write.
- R5: After reset, `cfg_delay` is 100, `state_o` is HOLD (2), `supply_en` is 1 and `host_rst_n` is 0. The line is released after 100 ticks.
- R6: While a soft request is pending and no hard request is pending, the state is SOFT (`state_o` = 1) and `supply_en` stays 1.
- R7: A hard request moves the block to FAULT (`state_o` = 3) with `supply_en` = 0 on the next edge, even while a soft request is pending.
- R8: A request that reappears during HOLD moves the block back to SOFT. The full delay is counted again from zero once it clears.
- R9: FAULT is left only on an edge where `recover` is 1 and no hard request is pending. The block then goes to HOLD (or to SOFT if a soft request is pending) with `supply_en` = 1. Until then it stays in FAULT with `host_rst_n` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| soft_req | input | N_SOFT | Soft reset requests, active high |
| hard_req | input | N_HARD | Hard reset requests, active high |
| recover | input | 1 | Recovery strobe used to leave FAULT |
| cfg_we | input | 1 | Write enable for the delay setting |
| cfg_wdata | input | 12 | Requested delay in ticks, before limiting |
| cfg_delay | output | 11 | Stored delay in ticks, after limiting |
| host_rst_n | output | 1 | Active-low reset to the host |
| supply_en | output | 1 | Supply enable, low in FAULT |
| state_o | output | 2 | State code: 0 ACTIVE, 1 SOFT, 2 HOLD, 3 FAULT |

## Verification
The assertions assume three things about the inputs:

- The request inputs are synchronous to `clk`.
- The delay setting is written only while the block is in ACTIVE, so the delay limit does not move while a count is running.
- The clock-to-tick ratio is at least two, so a tick is always followed by a quiet cycle.

The stimulus respects these assumptions:

- All inputs change one time unit after a falling edge.
- Every delay write is issued after a release has been observed.
- The bench sets CLK_HZ so that DIV is 5.

With DIV at 5, the shortest delay of 20 ticks and the longest of 2000 ticks both finish within the run.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

    localparam int DLY_W   = 11;
    localparam int CFG_W   = 12;
    localparam int DLY_MIN = 20;
    localparam int DLY_MAX = 2000;
    localparam int DLY_DEF = 100;
    localparam int TICK_HZ = 100_000;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_SOFT   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_FAULT  = 2'd3
    } sup_state_e;

endpackage

// File: rtl/rstsup_tick_gen.sv
module rstsup_tick_gen #(
    parameter int CLK_HZ = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    import rstsup_pkg::*;

    localparam int DIV = CLK_HZ / TICK_HZ;
    localparam int PW  = (DIV > 2) ? $clog2(DIV) : 1;

    generate
        if (DIV < 2) begin : g_direct
            assign tick = run;
        end else begin : g_div
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pcnt <= '0;
                end else if (!run) begin
                    pcnt <= '0;
                end else if (pcnt == PW'(DIV - 1)) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end

            assign tick = run && (pcnt == PW'(DIV - 1));

            // R3: a tick is a single-cycle pulse
            a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
            // R3: the prescaler never passes its terminal count
            a_r3_pcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
                pcnt <= PW'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/rstsup_delay_reg.sv
module rstsup_delay_reg
    import rstsup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [DLY_W-1:0] delay
);

    function automatic logic [DLY_W-1:0] limit_delay(input logic [CFG_W-1:0] v);
        if (v < CFG_W'(DLY_MIN)) begin
            return DLY_W'(DLY_MIN);
        end else if (v > CFG_W'(DLY_MAX)) begin
            return DLY_W'(DLY_MAX);
        end else begin
            return v[DLY_W-1:0];
        end
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            delay <= DLY_W'(DLY_DEF);
        end else if (we) begin
            delay <= limit_delay(wdata);
        end
    end

    // R4: the stored delay never leaves the legal window
    a_r4_delay_window: assert property (@(posedge clk) disable iff (!rst_n)
        (delay >= DLY_W'(DLY_MIN)) && (delay <= DLY_W'(DLY_MAX)));
    // R4: without a write the setting holds
    a_r4_delay_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(delay));

endmodule

// File: rtl/rstsup_delay_cnt.sv
module rstsup_delay_cnt
    import rstsup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [DLY_W-1:0] limit,
    output logic             expired
);

    logic [DLY_W-1:0] cnt;
    logic [DLY_W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && (cnt < limit)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = tick && !clr && (cnt_nxt >= {1'b0, limit});

    // R2: the tick count stays within the largest legal delay
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DLY_W'(DLY_MAX));
    // R8: a clear restarts the count from zero
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
    import rstsup_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000,
    parameter int N_SOFT = 4,
    parameter int N_HARD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SOFT-1:0] soft_req,
    input  logic [N_HARD-1:0] hard_req,
    input  logic              recover,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [DLY_W-1:0]  cfg_delay,
    output logic              host_rst_n,
    output logic              supply_en,
    output logic [1:0]        state_o
);

    sup_state_e state, state_nxt;
    logic       any_soft, any_hard;
    logic       tick, expired, hold_run;

    assign any_soft = |soft_req;
    assign any_hard = |hard_req;
    assign hold_run = (state == ST_HOLD);

    rstsup_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (hold_run),
        .tick  (tick)
    );

    rstsup_delay_reg u_dreg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .delay (cfg_delay)
    );

    rstsup_delay_cnt u_dcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!hold_run),
        .tick    (tick),
        .limit   (cfg_delay),
        .expired (expired)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ACTIVE: begin
                if (any_hard)      state_nxt = ST_FAULT;
                else if (any_soft) state_nxt = ST_SOFT;
            end
            ST_SOFT: begin
                if (any_hard)      state_nxt = ST_FAULT;
                else if (!any_soft) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (any_hard)      state_nxt = ST_FAULT;
                else if (any_soft) state_nxt = ST_SOFT;
                else if (expired)  state_nxt = ST_ACTIVE;
            end
            ST_FAULT: begin
                if (recover && !any_hard)
                    state_nxt = any_soft ? ST_SOFT : ST_HOLD;
            end
            default: state_nxt = ST_FAULT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nxt;
    end

    // outputs
    always_comb begin
        host_rst_n = 1'b0;
        supply_en  = 1'b1;
        unique case (state)
            ST_ACTIVE: host_rst_n = 1'b1;
            ST_SOFT:   host_rst_n = 1'b0;
            ST_HOLD:   host_rst_n = 1'b0;
            ST_FAULT:  supply_en  = 1'b0;
            default:   supply_en  = 1'b0;
        endcase
    end

    assign state_o = state;

    // R1: any request pulls the host reset low on the next cycle
    a_r1_req_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        (any_soft || any_hard) |=> !host_rst_n);
    // R2: release only follows an expired delay count
    a_r2_release_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rst_n) |-> $past(expired));
    // R6: a soft-only request keeps supplies on
    a_r6_soft_supply_on: assert property (@(posedge clk) disable iff (!rst_n)
        (any_soft && !any_hard && state != ST_FAULT) |=> (supply_en && state == ST_SOFT));
    // R7: a hard request forces FAULT with supplies off
    a_r7_hard_fault: assert property (@(posedge clk) disable iff (!rst_n)
        any_hard |=> (state == ST_FAULT && !supply_en && !host_rst_n));
    // R9: FAULT holds without a usable recovery strobe
    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && (!recover || any_hard)) |=> (state == ST_FAULT));

endmodule

// File: tb/rstsup_top_bench.sv
module rstsup_top_bench;
    import rstsup_pkg::*;

    localparam int CLK_HZ = 500_000;
    localparam int DIV    = CLK_HZ / TICK_HZ;
    localparam int NS     = 4;
    localparam int NH     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     soft_req = '0;
    logic [NH-1:0]     hard_req = '0;
    logic              recover = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [DLY_W-1:0]  cfg_delay;
    logic              host_rst_n;
    logic              supply_en;
    logic [1:0]        state_o;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_q[$];
    int hold_cnt = 0;
    logic prev_host = 1'b0;

    always #4 clk = ~clk;

    rstsup_top #(.CLK_HZ(CLK_HZ), .N_SOFT(NS), .N_HARD(NH)) u_rstsup_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_req   (soft_req),
        .hard_req   (hard_req),
        .recover    (recover),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_delay  (cfg_delay),
        .host_rst_n (host_rst_n),
        .supply_en  (supply_en),
        .state_o    (state_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: measures each HOLD run that ends in a release
    always @(negedge clk) begin
        if (rst_n) begin
            if (!prev_host && host_rst_n) begin
                if (exp_q.size() > 0) check("R2 hold length", hold_cnt, exp_q.pop_front());
                hold_cnt = 0;
            end else if (state_o == 2'd2) begin
                hold_cnt++;
            end else begin
                hold_cnt = 0;
            end
            prev_host = host_rst_n;
        end
    end

    task automatic wait_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!host_rst_n && n < 20000);
    endtask

    task automatic cfg_write(input int v, input int exp);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = CFG_W'(v);
        @(negedge clk);
        check("R4 delay readback", int'(cfg_delay), exp);
        #1 cfg_we = 1'b0;
    endtask

    task automatic soft_burst(input int idx, input int len, input int exp_len);
        @(negedge clk); #1;
        soft_req[idx] = 1'b1;
        @(negedge clk);
        check("R1 host low after soft", int'(host_rst_n), 0);
        check("R6 soft state", int'(state_o), 1);
        check("R6 supply on", int'(supply_en), 1);
        repeat (len) @(negedge clk);
        #1;
        if (exp_len > 0) exp_q.push_back(exp_len);
        soft_req[idx] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R5 reset delay", int'(cfg_delay), DLY_DEF);
        check("R5 reset state", int'(state_o), 2);
        check("R5 reset host low", int'(host_rst_n), 0);
        check("R5 reset supply on", int'(supply_en), 1);
        #1 rst_n = 1'b1;
        wait_release(n);
        check("R5 power-on release cycles", n, DLY_DEF * DIV);

        cfg_write(20, 20);
        cfg_write(5, 20);
        cfg_write(3000, 2000);
        cfg_write(37, 37);

        // soft request then clean release
        soft_burst(0, 3, 37 * DIV);
        wait_release(n);
        check("R2 released", int'(host_rst_n), 1);

        // request re-appears mid-hold: R8
        soft_burst(1, 2, 0);
        repeat (50) @(negedge clk);
        check("R8 in hold", int'(state_o), 2);
        soft_burst(2, 2, 37 * DIV);
        wait_release(n);
        check("R8 released", int'(host_rst_n), 1);

        // hard during soft: R7
        @(negedge clk); #1 soft_req[0] = 1'b1;
        @(negedge clk); #1 hard_req[1] = 1'b1;
        @(negedge clk);
        check("R7 fault state", int'(state_o), 3);
        check("R7 supply off", int'(supply_en), 0);
        #1 soft_req = '0; hard_req = '0;
        repeat (20) @(negedge clk);
        check("R9 stays fault", int'(state_o), 3);
        check("R9 host low in fault", int'(host_rst_n), 0);
        // recovery with hard still pending is ignored
        #1 hard_req[0] = 1'b1; recover = 1'b1;
        @(negedge clk);
        check("R9 recover ignored", int'(state_o), 3);
        check("R9 supply still off", int'(supply_en), 0);
        #1 recover = 1'b0; hard_req = '0;
        @(negedge clk); #1;
        exp_q.push_back(37 * DIV);
        recover = 1'b1;
        @(negedge clk);
        check("R9 recovered to hold", int'(state_o), 2);
        check("R9 supply back on", int'(supply_en), 1);
        #1 recover = 1'b0;
        wait_release(n);
        check("R9 released", int'(host_rst_n), 1);

        // shortest and longest delays: R3 tick period
        cfg_write(20, 20);
        soft_burst(3, 1, 20 * DIV);
        wait_release(n);
        check("R3 released min", int'(host_rst_n), 1);
        cfg_write(2000, 2000);
        soft_burst(0, 1, 2000 * DIV);
        wait_release(n);
        check("R3 released max", int'(host_rst_n), 1);

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule